// File: doc/BRIEF.md
# Data Address Generator with Pointer Masking

This block forms the effective data address of a load or store. It adds a 64-bit base register value to a sign-extended 12-bit immediate offset. It then applies a pointer-masking transform that clears the top N bits of the full 64-bit sum. The enable and the value of N are programmed separately for each privilege level. The addition always completes across the full width before any masking. A carry that ripples up into the masked field is therefore lost, and those bits read as zero.

The masked address goes to three places, each through its own output: address translation, the debug address-trigger comparator, and the trap-value path used when the access faults. The block also contains an exact-equality trigger comparator, which raises a hit flag for a valid access while the trigger is enabled. Only data addresses pass through this unit. Instruction-fetch addresses and branch targets never use it. All results appear one clock after the input valid, through a single register stage.

Top module: `pm_lsu_agu`

## Requirements
- R1: When masking is off for the current privilege, `xlat_addr` equals `base + sign_extend(offset)` modulo 2^64. Offset bit 11 is the sign bit.
- R2: Masking acts on the finished 64-bit sum. When masking is active with count N, bits [63:64-N] of the output are zero, even if the addition carried into them. The lower bits equal the sum.
- R3: The effective N is the programmed count clamped to at most 32. A count of 0 leaves the sum unchanged. Any count above 32 behaves exactly as 32.
- R4: Control is chosen by `priv`. Code 2'b00 (user) uses `pm_en[0]` and `pm_cnt[5:0]`. Code 2'b01 (supervisor) uses `pm_en[1]` and `pm_cnt[11:6]`. Code 2'b11 (machine) uses `pm_en[2]` and `pm_cnt[17:12]`. Code 2'b10 never masks.
- R5: `out_valid` in cycle t+1 equals `in_valid` in cycle t. The three address outputs and `trig_hit` for an access appear in that same cycle as `out_valid`.
- R6: `tval_addr` and `dbg_addr` always carry the same masked value as `xlat_addr`.
- R7: `trig_hit` is 1 only for a valid access with `trig_en` high whose masked address exactly equals `trig_addr`. It is 0 otherwise.
- R8: While `rst_n` is low, `out_valid` and `trig_hit` are 0 and all three address outputs are 0.
- R9: In a cycle after `in_valid` was low, the address outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Access request valid |
| base | input | 64 | Base register value |
| offset | input | 12 | Signed immediate offset |
| priv | input | 2 | Privilege: 00 user, 01 supervisor, 11 machine, 10 reserved |
| pm_en | input | 3 | Per-privilege masking enable (bit0 U, bit1 S, bit2 M) |
| pm_cnt | input | 18 | Per-privilege masked-bit count, 6 bits each (U low) |
| trig_en | input | 1 | Address trigger enable |
| trig_addr | input | 64 | Address trigger compare value |
| out_valid | output | 1 | Result valid |
| xlat_addr | output | 64 | Masked address for translation |
| dbg_addr | output | 64 | Masked address seen by the trigger comparator |
| tval_addr | output | 64 | Masked address reported on a fault |
| trig_hit | output | 1 | Trigger match flag |

## Verification
The assertions check several properties on every cycle: the one-cycle valid latency, that the held outputs stay stable, that the low 32 bits always follow the raw sum, that the top bit clears whenever user masking is active, that the reserved privilege passes the sum through, that the three address copies agree, and the conditions under which a trigger hit may occur. The bench's scenarios cover what the assertions cannot. These are the exact bit count cleared for each N, including the clamp above 32 and a count of zero. They also include the carry-loss examples, the negative-offset wrap, the selection of each privilege's own control field, and exact trigger matches against masked addresses. A behavioural model is compared with the outputs on every clock across both directed and pseudo-random stimulus.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int unsigned PM_NPRIV = 3;

  typedef enum logic [1:0] {
    PRIV_USR = 2'b00,
    PRIV_SUP = 2'b01,
    PRIV_RSV = 2'b10,
    PRIV_MCH = 2'b11
  } priv_e;
endpackage

// File: rtl/pm_addr_add.sv
module pm_addr_add #(
  parameter int unsigned AW = 64,
  parameter int unsigned OW = 12
) (
  input  logic [AW-1:0] base,
  input  logic [OW-1:0] offset,
  output logic [AW-1:0] sum
);
  function automatic logic [AW-1:0] sext(input logic [OW-1:0] v);
    return {{(AW-OW){v[OW-1]}}, v};
  endfunction

  // full-width sum; no masking here, so carries are computed normally
  assign sum = base + sext(offset);
endmodule

// File: rtl/pm_mask_sel.sv
module pm_mask_sel
  import pm_pkg::*;
#(
  parameter int unsigned AW   = 64,
  parameter int unsigned CW   = 6,
  parameter int unsigned MAXN = 32
) (
  input  logic [1:0]             priv,
  input  logic [PM_NPRIV-1:0]    pm_en,
  input  logic [PM_NPRIV*CW-1:0] pm_cnt,
  input  logic [AW-1:0]          sum,
  output logic [AW-1:0]          masked
);
  localparam int unsigned NW = $clog2(AW + 1);

  function automatic logic [NW-1:0] clamp_n(input logic [CW-1:0] c);
    if (32'(c) > MAXN) return NW'(MAXN);
    return NW'(c);
  endfunction

  function automatic logic [AW-1:0] keep_mask(input logic [NW-1:0] n);
    logic [AW-1:0] m;
    for (int i = 0; i < AW; i++) m[i] = (32'(i) < (AW - 32'(n)));
    return m;
  endfunction

  logic [NW-1:0] n_priv [PM_NPRIV];

  for (genvar g = 0; g < PM_NPRIV; g++) begin : g_clamp
    assign n_priv[g] = pm_en[g] ? clamp_n(pm_cnt[g*CW +: CW]) : '0;
  end

  logic [NW-1:0] n_sel;

  always_comb begin
    case (priv_e'(priv))
      PRIV_USR: n_sel = n_priv[0];
      PRIV_SUP: n_sel = n_priv[1];
      PRIV_MCH: n_sel = n_priv[2];
      default:  n_sel = '0;
    endcase
  end

  assign masked = sum & keep_mask(n_sel);
endmodule

// File: rtl/pm_trig_cmp.sv
module pm_trig_cmp #(
  parameter int unsigned AW = 64
) (
  input  logic          valid,
  input  logic          en,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] target,
  output logic          hit
);
  assign hit = valid && en && (addr == target);
endmodule

// File: rtl/pm_lsu_agu.sv
module pm_lsu_agu
  import pm_pkg::*;
#(
  parameter int unsigned AW   = 64,
  parameter int unsigned OW   = 12,
  parameter int unsigned CW   = 6,
  parameter int unsigned MAXN = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [AW-1:0]          base,
  input  logic [OW-1:0]          offset,
  input  logic [1:0]             priv,
  input  logic [PM_NPRIV-1:0]    pm_en,
  input  logic [PM_NPRIV*CW-1:0] pm_cnt,
  input  logic                   trig_en,
  input  logic [AW-1:0]          trig_addr,
  output logic                   out_valid,
  output logic [AW-1:0]          xlat_addr,
  output logic [AW-1:0]          dbg_addr,
  output logic [AW-1:0]          tval_addr,
  output logic                   trig_hit
);
  logic [AW-1:0] sum_w;
  logic [AW-1:0] masked_w;
  logic          hit_w;

  pm_addr_add #(.AW(AW), .OW(OW)) i_add (
    .base   (base),
    .offset (offset),
    .sum    (sum_w)
  );

  pm_mask_sel #(.AW(AW), .CW(CW), .MAXN(MAXN)) i_mask (
    .priv   (priv),
    .pm_en  (pm_en),
    .pm_cnt (pm_cnt),
    .sum    (sum_w),
    .masked (masked_w)
  );

  pm_trig_cmp #(.AW(AW)) i_trig (
    .valid  (in_valid),
    .en     (trig_en),
    .addr   (masked_w),
    .target (trig_addr),
    .hit    (hit_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      trig_hit  <= 1'b0;
      xlat_addr <= '0;
      dbg_addr  <= '0;
      tval_addr <= '0;
    end else begin
      out_valid <= in_valid;
      trig_hit  <= hit_w;
      if (in_valid) begin
        xlat_addr <= masked_w;
        dbg_addr  <= masked_w;
        tval_addr <= masked_w;
      end
    end
  end
endmodule

// File: rtl/pm_lsu_agu_chk.sv
module pm_lsu_agu_chk
  import pm_pkg::*;
#(
  parameter int unsigned AW   = 64,
  parameter int unsigned OW   = 12,
  parameter int unsigned CW   = 6,
  parameter int unsigned MAXN = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic [1:0]             priv,
  input logic [PM_NPRIV-1:0]    pm_en,
  input logic [PM_NPRIV*CW-1:0] pm_cnt,
  input logic                   trig_en,
  input logic [AW-1:0]          trig_addr,
  input logic                   out_valid,
  input logic [AW-1:0]          xlat_addr,
  input logic [AW-1:0]          dbg_addr,
  input logic [AW-1:0]          tval_addr,
  input logic                   trig_hit,
  input logic [AW-1:0]          sum_w
);
  p_lat_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_lat_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(xlat_addr));
  p_copies_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (tval_addr == xlat_addr) && (dbg_addr == xlat_addr));
  p_low_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> xlat_addr[AW-MAXN-1:0] == $past(sum_w[AW-MAXN-1:0]));
  p_carry_lost_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && priv == 2'b00 && pm_en[0] && pm_cnt[CW-1:0] != '0)
      |=> !xlat_addr[AW-1]);
  p_rsv_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && priv == 2'b10) |=> xlat_addr == $past(sum_w));
  p_hit_cond_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trig_hit |-> out_valid && $past(trig_en) && (dbg_addr == $past(trig_addr)));
endmodule

bind pm_lsu_agu pm_lsu_agu_chk #(.AW(AW), .OW(OW), .CW(CW), .MAXN(MAXN)) i_chk (.*);

// File: tb/test_pm_lsu_agu.sv
`timescale 1ns/1ps
module test_pm_lsu_agu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] base = '0;
  logic [11:0] offset = '0;
  logic [1:0]  priv = '0;
  logic [2:0]  pm_en = '0;
  logic [17:0] pm_cnt = '0;
  logic        trig_en = 1'b0;
  logic [63:0] trig_addr = '0;
  logic        out_valid, trig_hit;
  logic [63:0] xlat_addr, dbg_addr, tval_addr;

  int checks = 0;
  int errors = 0;
  logic [63:0] exp_addr = '0;
  logic        exp_vld = 1'b0;
  logic        exp_hit = 1'b0;

  always #4 clk = ~clk;

  pm_lsu_agu i_pm_lsu_agu (.*);

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // behavioural reference: add with 64-bit wrap, then zero the top bits one by one
  function automatic logic [63:0] ref_addr(logic [63:0] b, logic [11:0] o, logic [1:0] p,
                                           logic [2:0] en, logic [17:0] cnt);
    logic [63:0] a;
    int n, idx;
    a = b + 64'(longint'($signed(o)));
    case (p)
      2'b00: idx = 0;
      2'b01: idx = 1;
      2'b11: idx = 2;
      default: idx = -1;
    endcase
    n = 0;
    if (idx >= 0 && en[idx]) n = int'(cnt[idx*6 +: 6]);
    if (n > 32) n = 32;
    for (int k = 0; k < n; k++) a[63-k] = 1'b0;
    return a;
  endfunction

  // drive one cycle; compare on the following falling edge
  task automatic step(string tag, logic v, logic [63:0] b, logic [11:0] o, logic [1:0] p,
                      logic te, logic [63:0] ta);
    logic [63:0] r;
    in_valid = v; base = b; offset = o; priv = p; trig_en = te; trig_addr = ta;
    r = ref_addr(b, o, p, pm_en, pm_cnt);
    exp_vld = v;
    if (v) exp_addr = r;
    exp_hit = v && te && (r == ta);
    @(negedge clk);
    chk({tag, " R5 valid"}, 64'(out_valid), 64'(exp_vld));
    chk({tag, " addr"}, xlat_addr, exp_addr);
    chk({tag, " R6 tval"}, tval_addr, exp_addr);
    chk({tag, " R6 dbg"}, dbg_addr, exp_addr);
    chk({tag, " R7 hit"}, 64'(trig_hit), 64'(exp_hit));
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] seed;
    in_valid = 1'b1; base = 64'hFFFF_FFFF_FFFF_FFFF; trig_en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 valid", 64'(out_valid), 0);
    chk("R8 addr", xlat_addr, 0);
    chk("R8 tval", tval_addr, 0);
    chk("R8 hit", 64'(trig_hit), 0);
    in_valid = 1'b0; trig_en = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    // R1: no masking, positive and negative offsets
    pm_en = 3'b000;
    step("R1 plain", 1, 64'hABCD_FFFF_FFFF_FFF0, 12'h010, 2'b00, 0, 0);
    chk("R1 carry kept", xlat_addr, 64'hABCE_0000_0000_0000);
    step("R1 neg", 1, 64'h10, 12'hFE0, 2'b00, 0, 0);
    chk("R1 wrap", xlat_addr, 64'hFFFF_FFFF_FFFF_FFF0);

    // R2: carry into masked field is lost
    pm_en = 3'b001; pm_cnt = 18'd16;
    step("R2 carry", 1, 64'hABCD_FFFF_FFFF_FFF0, 12'h010, 2'b00, 0, 0);
    chk("R2 carry gone", xlat_addr, 64'h0);
    pm_cnt = 18'd4;
    step("R2 n4", 1, 64'hF000_0000_0000_0000, 12'h000, 2'b00, 0, 0);
    chk("R2 n4 zero", tval_addr, 64'h0);

    // R3: clamp and zero count
    pm_cnt = 18'd32;
    step("R3 n32", 1, 64'h10, 12'hFE0, 2'b00, 0, 0);
    chk("R3 n32 val", xlat_addr, 64'h0000_0000_FFFF_FFF0);
    pm_cnt = 18'd40;
    step("R3 n40", 1, 64'h10, 12'hFE0, 2'b00, 0, 0);
    chk("R3 clamp", xlat_addr, 64'h0000_0000_FFFF_FFF0);
    pm_cnt = 18'd0;
    step("R3 n0", 1, 64'h10, 12'hFE0, 2'b00, 0, 0);
    chk("R3 zero count", xlat_addr, 64'hFFFF_FFFF_FFFF_FFF0);

    // R4: each privilege uses its own field; reserved never masks
    pm_en = 3'b111; pm_cnt = {6'd8, 6'd16, 6'd4};
    step("R4 user", 1, 64'hFFFF_FFFF_0000_0000, 12'h0, 2'b00, 0, 0);
    chk("R4 user n4", xlat_addr, 64'h0FFF_FFFF_0000_0000);
    step("R4 sup", 1, 64'hFFFF_FFFF_0000_0000, 12'h0, 2'b01, 0, 0);
    chk("R4 sup n16", xlat_addr, 64'h0000_FFFF_0000_0000);
    step("R4 mach", 1, 64'hFFFF_FFFF_0000_0000, 12'h0, 2'b11, 0, 0);
    chk("R4 mach n8", xlat_addr, 64'h00FF_FFFF_0000_0000);
    step("R4 rsv", 1, 64'hFFFF_FFFF_0000_0000, 12'h0, 2'b10, 0, 0);
    chk("R4 rsv none", xlat_addr, 64'hFFFF_FFFF_0000_0000);
    pm_en = 3'b110;
    step("R4 user off", 1, 64'hFFFF_FFFF_0000_0000, 12'h0, 2'b00, 0, 0);
    chk("R4 user disabled", xlat_addr, 64'hFFFF_FFFF_0000_0000);

    // R7: trigger compares masked address
    pm_en = 3'b001; pm_cnt = 18'd16;
    step("R7 match", 1, 64'hABCD_0000_1234_5678, 12'h0, 2'b00, 1, 64'h0000_0000_1234_5678);
    chk("R7 masked hit", 64'(trig_hit), 1);
    step("R7 raw miss", 1, 64'hABCD_0000_1234_5678, 12'h0, 2'b00, 1, 64'hABCD_0000_1234_5678);
    chk("R7 raw addr no hit", 64'(trig_hit), 0);
    step("R7 disabled", 1, 64'hABCD_0000_1234_5678, 12'h0, 2'b00, 0, 64'h0000_0000_1234_5678);
    step("R7 invalid", 0, 64'hABCD_0000_1234_5678, 12'h0, 2'b00, 1, 64'h0000_0000_1234_5678);

    // R9: idle cycles hold the address
    step("R9 hold", 0, 64'h1234, 12'h1, 2'b00, 0, 0);
    chk("R9 held", xlat_addr, 64'h0000_0000_1234_5678);

    // pseudo-random sweep with the reference model compared every cycle
    seed = 64'h1357_9BDF_2468_ACE0;
    for (int i = 0; i < 400; i++) begin
      logic [63:0] b;
      seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
      b = seed;
      seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
      pm_en = seed[2:0];
      pm_cnt = seed[20:3];
      step("R2 R3 R4 rnd", seed[63:62] != 2'b00, b, seed[40:29], seed[45:44], seed[50],
           seed[51] ? ref_addr(b, seed[40:29], seed[45:44], seed[2:0], seed[20:3]) : b);
    end

    in_valid = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule